// File: doc/BRIEF.md
# Interrupt Stacking Sequencer

This block carries out the memory traffic for entering and leaving an interrupt handler in an 8-bit processor whose stack pointer and program counter are 16 bits wide. On an entry command it saves the program counter, the index register, the accumulator and the condition-code register to the stack. It then sets the interrupt mask and fetches the new program counter from a two-byte vector. On a return command it reads the same five bytes back and restores every register.

The core's sequencer raises `start` for one cycle, with `op` selecting the command, and presents the current register values. The block then owns a single-port byte memory interface for a fixed number of cycles. It makes at most one access per cycle and leaves the remaining cycles idle, so that both sequences always take the same time. The updated register set appears on the outputs in the cycle in which `done` pulses, and it is held until the next command completes.

Top module: `irq_stack_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `mem_we` and `mem_re` are 0, and `mem_addr`, `mem_wdata` and all register outputs are 0.
- R2: A command is accepted at the clock edge where `start`=1 and `busy`=0. For op 2'b00 (hardware entry) the stacked PC is `pc_in`; for op 2'b01 (software entry) it is `pc_in`+1. In cycles 0 to 4 after acceptance the block writes PC low, PC high, X, A and CCR at addresses SP, SP-1, SP-2, SP-3 and SP-4.
- R3: There is never a read and a write in the same cycle. In entry cycles 5 and 6 the block reads the vector high byte at VEC_ADDR (default 16'hFFFE) and then the low byte at VEC_ADDR+1. Read data is taken from `mem_rdata` one cycle after the read cycle.
- R4: On completion of an entry, `pc_out` holds the vector, `sp_out` = SP-5, `ccr_out` = stacked CCR with bit 3 (interrupt mask) set and all other bits unchanged, and `a_out`/`x_out` equal the sampled A and X.
- R5: An entry keeps `busy` high for exactly 9 cycles, with no memory access in cycles 7 and 8. `done` is high only in cycle 8.
- R6: For op 2'b10 (return), cycles 0 to 4 read CCR, A, X, PC high and PC low at SP+1, SP+2, SP+3, SP+4 and SP+5.
- R7: On completion of a return, `ccr_out`, `a_out`, `x_out` and `pc_out` hold the values read, including the stacked interrupt-mask bit, and `sp_out` = SP+5.
- R8: A return keeps `busy` high for exactly 7 cycles, with no access in cycles 5 and 6. `done` is high only in cycle 6.
- R9: `start` while `busy`=1 is ignored and leaves the running sequence unchanged. `start` with op 2'b11 is ignored: `busy` stays 0 and no access occurs.
- R10: Register outputs keep their last completed values while idle, whatever the register inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| op | input | 2 | 00 hardware entry, 01 software entry, 10 return, 11 reserved |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| ccr_in | input | 8 | Current condition codes |
| mem_rdata | input | 8 | Read data, one cycle after the read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| pc_out | output | 16 | New or restored program counter |
| sp_out | output | 16 | Updated stack pointer |
| a_out | output | 8 | Resulting accumulator |
| x_out | output | 8 | Resulting index register |
| ccr_out | output | 8 | Resulting condition codes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench checks every cycle of each sequence against the expected access, so a swapped frame order, an off-by-one stack address, or a pre-decrement in place of a post-decrement shows up as a wrong address or data byte in a named cycle. A vector fetched low byte first, or data captured without the one-cycle read latency, leaves a wrong program counter after entry. A software entry at PC 16'hFFFF must stack 16'h0000, and a hardware entry must stack the PC unchanged. A return whose stacked mask bit is clear must clear the mask; a design that forces the bit would leave it set. A start strobe during a sequence, or with the reserved op, must change nothing; a design that restarts would shift every later access.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    OP_HW   = 2'b00,
    OP_SW   = 2'b01,
    OP_RET  = 2'b10,
    OP_RSVD = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_ENTRY  = 2'b01,
    MODE_RETURN = 2'b10
  } seq_mode_e;

  localparam int unsigned FRAME_BYTES   = 5;
  localparam int unsigned ENTRY_CYCLES  = 9;
  localparam int unsigned RETURN_CYCLES = 7;
  localparam int unsigned STEP_W        = $clog2(ENTRY_CYCLES + 1);
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  output seq_mode_e         mode,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              done,
  output logic              launch,
  output seq_mode_e         nmode,
  output logic [STEP_W-1:0] nstep,
  output logic              nactive
);
  localparam logic [STEP_W-1:0] LAST_ENT = STEP_W'(ENTRY_CYCLES - 1);
  localparam logic [STEP_W-1:0] LAST_RET = STEP_W'(RETURN_CYCLES - 1);

  logic [STEP_W-1:0] last_c, nlast_c;
  logic              cont_c;

  always_comb begin
    launch  = start && !busy && (op != OP_RSVD);
    last_c  = (mode == MODE_ENTRY) ? LAST_ENT : LAST_RET;
    cont_c  = busy && (step != last_c);
    nactive = launch || cont_c;
    nstep   = launch ? '0 : step + 1'b1;
    if (launch)      nmode = (op == OP_RET) ? MODE_RETURN : MODE_ENTRY;
    else if (cont_c) nmode = mode;
    else             nmode = MODE_IDLE;
    nlast_c = (nmode == MODE_ENTRY) ? LAST_ENT : LAST_RET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_IDLE;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      mode <= nmode;
      step <= nactive ? nstep : '0;
      busy <= nactive;
      done <= nactive && (nstep == nlast_c);
    end
  end
endmodule

// File: rtl/irq_seq_memport.sv
module irq_seq_memport
  import irq_seq_pkg::*;
#(
  parameter int unsigned   DW       = 8,
  parameter logic [2*DW-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nactive,
  input  seq_mode_e         nmode,
  input  logic [STEP_W-1:0] nstep,
  input  logic [2*DW-1:0]   ctx_sp,
  input  logic [2*DW-1:0]   ctx_pc,
  input  logic [DW-1:0]     ctx_a,
  input  logic [DW-1:0]     ctx_x,
  input  logic [DW-1:0]     ctx_ccr,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [STEP_W-1:0] S_FRAME  = STEP_W'(FRAME_BYTES);
  localparam logic [STEP_W-1:0] S_VEC_HI = STEP_W'(FRAME_BYTES);
  localparam logic [STEP_W-1:0] S_VEC_LO = STEP_W'(FRAME_BYTES + 1);

  logic [AW-1:0] addr_n;
  logic [DW-1:0] wdata_n;
  logic          we_n, re_n;

  always_comb begin
    addr_n  = '0;
    wdata_n = '0;
    we_n    = 1'b0;
    re_n    = 1'b0;
    if (nactive && nmode == MODE_ENTRY) begin
      if (nstep < S_FRAME) begin
        we_n   = 1'b1;
        addr_n = ctx_sp - AW'(nstep);
        case (nstep)
          STEP_W'(0): wdata_n = ctx_pc[DW-1:0];
          STEP_W'(1): wdata_n = ctx_pc[AW-1:DW];
          STEP_W'(2): wdata_n = ctx_x;
          STEP_W'(3): wdata_n = ctx_a;
          default:    wdata_n = ctx_ccr;
        endcase
      end else if (nstep == S_VEC_HI) begin
        re_n   = 1'b1;
        addr_n = VEC_ADDR;
      end else if (nstep == S_VEC_LO) begin
        re_n   = 1'b1;
        addr_n = VEC_ADDR + 1'b1;
      end
    end else if (nactive && nmode == MODE_RETURN && nstep < S_FRAME) begin
      re_n   = 1'b1;
      addr_n = ctx_sp + AW'(nstep) + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      mem_addr  <= addr_n;
      mem_wdata <= wdata_n;
      mem_we    <= we_n;
      mem_re    <= re_n;
    end
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned     DW       = 8,
  parameter logic [2*DW-1:0] VEC_ADDR = 16'hFFFE,
  parameter int unsigned     I_BIT    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [2*DW-1:0] pc_in,
  input  logic [2*DW-1:0] sp_in,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   ccr_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [2*DW-1:0] pc_out,
  output logic [2*DW-1:0] sp_out,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [DW-1:0]   ccr_out,
  output logic            busy,
  output logic            done
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [AW-1:0] FRAME_ADJ = AW'(FRAME_BYTES);
  localparam logic [DW-1:0] I_MASK    = DW'(1) << I_BIT;
  // Read data is one cycle late, so capture happens one step after each read.
  localparam logic [STEP_W-1:0] S_ENT_HI = STEP_W'(FRAME_BYTES + 1);
  localparam logic [STEP_W-1:0] S_ENT_LO = STEP_W'(FRAME_BYTES + 2);
  localparam logic [STEP_W-1:0] S_RET_LO = STEP_W'(FRAME_BYTES);

  seq_mode_e         mode, nmode;
  logic [STEP_W-1:0] step, nstep;
  logic              launch, nactive;

  logic [AW-1:0] sp_s, pc_s, hi_w, ctx_sp, ctx_pc, pc_push;
  logic [DW-1:0] a_s, x_s, ccr_s, a_w, x_w, ccr_w;
  logic [DW-1:0] ctx_a, ctx_x, ctx_ccr;

  irq_seq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .mode(mode), .step(step), .busy(busy), .done(done),
    .launch(launch), .nmode(nmode), .nstep(nstep), .nactive(nactive)
  );

  always_comb begin
    pc_push = (op == OP_SW) ? pc_in + 1'b1 : pc_in;
    ctx_sp  = launch ? sp_in   : sp_s;
    ctx_pc  = launch ? pc_push : pc_s;
    ctx_a   = launch ? a_in    : a_s;
    ctx_x   = launch ? x_in    : x_s;
    ctx_ccr = launch ? ccr_in  : ccr_s;
  end

  irq_seq_memport #(.DW(DW), .VEC_ADDR(VEC_ADDR)) port_i (
    .clk(clk), .rst(rst), .nactive(nactive), .nmode(nmode), .nstep(nstep),
    .ctx_sp(ctx_sp), .ctx_pc(ctx_pc), .ctx_a(ctx_a), .ctx_x(ctx_x),
    .ctx_ccr(ctx_ccr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_s <= '0; pc_s <= '0; a_s <= '0; x_s <= '0; ccr_s <= '0;
      hi_w <= '0; a_w <= '0; x_w <= '0; ccr_w <= '0;
      pc_out <= '0; sp_out <= '0; a_out <= '0; x_out <= '0; ccr_out <= '0;
    end else begin
      if (launch) begin
        sp_s  <= sp_in;
        pc_s  <= pc_push;
        a_s   <= a_in;
        x_s   <= x_in;
        ccr_s <= ccr_in;
      end
      if (busy && mode == MODE_ENTRY) begin
        if (step == S_ENT_HI) hi_w <= {mem_rdata, {DW{1'b0}}};
        if (step == S_ENT_LO) begin
          pc_out  <= {hi_w[AW-1:DW], mem_rdata};
          sp_out  <= sp_s - FRAME_ADJ;
          ccr_out <= ccr_s | I_MASK;
          a_out   <= a_s;
          x_out   <= x_s;
        end
      end
      if (busy && mode == MODE_RETURN) begin
        case (step)
          STEP_W'(1): ccr_w <= mem_rdata;
          STEP_W'(2): a_w   <= mem_rdata;
          STEP_W'(3): x_w   <= mem_rdata;
          STEP_W'(4): hi_w  <= {mem_rdata, {DW{1'b0}}};
          S_RET_LO: begin
            pc_out  <= {hi_w[AW-1:DW], mem_rdata};
            sp_out  <= sp_s + FRAME_ADJ;
            ccr_out <= ccr_w;
            a_out   <= a_w;
            x_out   <= x_w;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done
);
  // R3: one access per cycle
  p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R2: back-to-back pushes walk the stack downward by one byte
  p_push_descend_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

  // R6: back-to-back reads walk upward by one byte
  p_read_ascend_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: completion ends the busy window
  p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy ##1 !busy));

  // R9: no memory access outside a sequence
  p_access_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);
endmodule

bind irq_stack_seq irq_seq_chk #(.AW(2*DW)) chk_i (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .busy(busy), .done(done)
);

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, ccr_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata, a_out, x_out, ccr_out;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem [0:255];
  int n_checks = 0;
  int n_errs   = 0;

  always #2 clk = ~clk;

  irq_stack_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .pc_in(pc_in),
    .sp_in(sp_in), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .pc_out(pc_out), .sp_out(sp_out),
    .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic b, w, r, d, input logic [15:0] ad, input logic [7:0] wd);
    return {4'b0, b, w, r, d, ad, wd};
  endfunction

  task automatic check_regs(input string tag, input logic [15:0] pc, sp, input logic [7:0] a, x, c);
    chk(pc_out == pc, {tag, " pc"}, 32'(pc_out), 32'(pc));
    chk(sp_out == sp, {tag, " sp"}, 32'(sp_out), 32'(sp));
    chk({a_out, x_out, ccr_out} == {a, x, c}, {tag, " a/x/ccr"},
        32'({a_out, x_out, ccr_out}), 32'({a, x, c}));
  endtask

  // R10: outputs hold while idle inputs wander
  task automatic hold_check(input logic [15:0] pc, sp, input logic [7:0] a, x, c);
    pc_in = 16'hDEAD; sp_in = 16'hBEEF; a_in = 8'h5C; x_in = 8'hC5; ccr_in = 8'hFF;
    repeat (3) @(negedge clk);
    check_regs("R10 hold", pc, sp, a, x, c);
  endtask

  task automatic run_entry(input bit sw, input logic [15:0] pc, sp, input logic [7:0] a, x, c,
                           input logic [15:0] vec, input bit poke);
    logic [15:0] ppc;
    logic [7:0]  fr [0:4];
    ppc = sw ? pc + 16'd1 : pc;
    fr[0] = ppc[7:0]; fr[1] = ppc[15:8]; fr[2] = x; fr[3] = a; fr[4] = c;
    @(negedge clk);
    pc_in = pc; sp_in = sp; a_in = a; x_in = x; ccr_in = c;
    op = sw ? 2'b01 : 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 9; k++) begin
      logic [31:0] e;
      string t;
      if (k < 5) begin e = pack(1, 1, 0, 0, sp - 16'(k), fr[k]); t = "R2 push"; end
      else if (k == 5) begin e = pack(1, 0, 1, 0, 16'hFFFE, 8'h00); t = "R3 vec hi"; end
      else if (k == 6) begin e = pack(1, 0, 1, 0, 16'hFFFF, 8'h00); t = "R3 vec lo"; end
      else begin e = pack(1, 0, 0, (k == 8), 16'h0, 8'h00); t = "R5 idle/done"; end
      if (poke && k == 2) t = {t, " R9 busy-start"};
      chk(pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata) == e, t,
          pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata), e);
      if (k == 8) check_regs("R4 entry", vec, sp - 16'd5, a, x, c | 8'h08);
      start = (poke && k == 1);
      op = (poke && k == 1) ? 2'b10 : op;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy == 1'b0, "R5 busy end", 32'(busy), 32'd0);
    hold_check(vec, sp - 16'd5, a, x, c | 8'h08);
  endtask

  task automatic run_return(input logic [15:0] sp, input logic [15:0] pc, input logic [7:0] a, x, c);
    @(negedge clk);
    sp_in = sp; op = 2'b10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 7; k++) begin
      logic [31:0] e;
      string t;
      if (k < 5) begin e = pack(1, 0, 1, 0, sp + 16'(k) + 16'd1, 8'h00); t = "R6 pull"; end
      else begin e = pack(1, 0, 0, (k == 6), 16'h0, 8'h00); t = "R8 idle/done"; end
      chk(pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata) == e, t,
          pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata), e);
      if (k == 6) check_regs("R7 return", pc, sp + 16'd5, a, x, c);
      @(negedge clk);
    end
    chk(busy == 1'b0, "R8 busy end", 32'(busy), 32'd0);
    hold_check(pc, sp + 16'd5, a, x, c);
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    chk(pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata) == 32'h0, "R1 during reset",
        pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata) == 32'h0, "R1 after reset",
        pack(busy, mem_we, mem_re, done, mem_addr, mem_wdata), 32'h0);
    check_regs("R1 regs", 16'h0, 16'h0, 8'h0, 8'h0, 8'h0);
  endtask

  task automatic test_reserved;
    @(negedge clk);
    op = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({busy, mem_we, mem_re} == 3'b000, "R9 reserved op", 32'({busy, mem_we, mem_re}), 32'd0);
    @(negedge clk);
    chk({busy, mem_we, mem_re, done} == 4'b0, "R9 reserved op later",
        32'({busy, mem_we, mem_re, done}), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_errs++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'hFE] = 8'h12; mem[8'hFF] = 8'h34;
    test_reset();
    run_entry(1'b1, 16'h4000, 16'h00F0, 8'h11, 8'h22, 8'h61, 16'h1234, 1'b1);
    run_return(16'h00EB, 16'h4001, 8'h11, 8'h22, 8'h61);
    test_reserved();
    check_regs("R9 reserved keeps regs", 16'h4001, 16'h00F0, 8'h11, 8'h22, 8'h61);
    mem[8'hFE] = 8'hA5; mem[8'hFF] = 8'h5A;
    run_entry(1'b0, 16'h8123, 16'h0080, 8'hFE, 8'h01, 8'hE8, 16'hA55A, 1'b0);
    run_return(16'h007B, 16'h8123, 8'hFE, 8'h01, 8'hE8);
    run_entry(1'b1, 16'hFFFF, 16'h00C0, 8'h80, 8'h7F, 8'h60, 16'hA55A, 1'b0);
    run_return(16'h00BB, 16'h0000, 8'h80, 8'h7F, 8'h60);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule